// File: doc/BRIEF.md
# Nested Two-Level Interrupt Priority Controller with Power-Fail Level

This block arbitrates interrupt requests for a small 8-bit microcontroller core. It takes five maskable source request lines and one power-fail request line. It holds an enable register and a per-source priority register that the core loads through simple write strobes. It sends the core an interrupt request and the vector address of the winning source. Each maskable source is assigned to a low or a high level. Power-fail sits on a third level above both of them.

The controller keeps one in-service flag per level. A request is taken only if its level is strictly above the highest level now in service. A high-level routine can therefore interrupt a low-level one, and power-fail can interrupt either. A request at the running level, or below it, waits for the core's return-from-interrupt pulse. That pulse retires the highest active level. When several eligible requests arrive together at one level, a fixed polling order picks the winner.

Request sampling and the arbitration result are both registered. A pending vector is handed over only when the core raises its fetch-ready strobe. In that same cycle the winning source gets a one-cycle acknowledge.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, irq is 0, vec_addr is 0x0000, every acknowledge output is 0, and both registers are cleared. No request is taken until software writes the enable register, even if all request lines are high.
- R2: A maskable source i (src_req bit i) is taken only when both of these enable-register bits are 1: bit i (its own enable) and bit NSRC+1 (the global enable, bit 6 by default).
- R3: The power-fail request is taken when enable-register bit NSRC (bit 5 by default) is 1, whatever the value of the global enable. When that bit is 0, the power-fail request is never taken.
- R4: Among pending requests at one level, the lowest src_req bit index wins. The bit order is 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial.
- R5: Priority-register bit i set to 1 puts source i on the high level, and 0 puts it on the low level. When requests at both levels are pending together, the high-level request wins.
- R6: While irq is 1, vec_addr is 0x0003 + 8*i for source i (0x0003, 0x000B, 0x0013, 0x001B, 0x0023) and 0x0033 for power-fail. While irq is 0, vec_addr is 0x0000.
- R7: While only the low level is in service, a high-level request raises irq with its vector.
- R8: A request at the level in service, or below it, is not taken until a return-from-interrupt pulse retires that level. This holds even for source 0.
- R9: A power-fail request is taken while any programmable level is in service. No maskable source is acknowledged while power-fail is in service.
- R10: Each reti pulse clears only the highest in-service flag. After a high-level routine nested over a low-level one, the first reti still leaves low-level requests blocked, and the second reti lets them through.
- R11: An acknowledge occurs only in a cycle with fetch_rdy=1 and irq=1. It is one-hot, it names the source whose vector is shown, and irq falls in the following cycle.
- R12: A request that is enabled and eligible, applied before a clock edge, raises irq after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_req | input | NSRC | Maskable request lines, bit index = polling place |
| pf_req | input | 1 | Power-fail request |
| ien_we | input | 1 | Write strobe for the enable register |
| ien_wdata | input | NSRC+2 | Enable data: per-source bits, power-fail enable at NSRC, global at NSRC+1 |
| pri_we | input | 1 | Write strobe for the priority register |
| pri_wdata | input | NSRC | Priority data, 1 = high level |
| fetch_rdy | input | 1 | Core is ready to take a vector |
| reti | input | 1 | Return-from-interrupt pulse from the core |
| irq | output | 1 | Interrupt request to the core |
| vec_addr | output | VEC_W | Vector address of the pending winner |
| src_ack | output | NSRC | One-cycle acknowledge per maskable source |
| pf_ack | output | 1 | One-cycle acknowledge for power-fail |

## Verification
The bench builds the block with its default parameters: five sources, a 16-bit vector, base 0x0003 and step 8. With these values every vector address, every polling position and the power-fail slot at 0x0033 can be checked directly. Five sources are enough to reach every nesting depth: low, high over low, and power-fail over high. They also let the bench test the reti sequence that unwinds one level at a time, and a source-0 request held back by a running routine of equal level.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_PF   = 2'd3
  } lvl_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ien_we,
  input  logic [NSRC+1:0] ien_wdata,
  input  logic            pri_we,
  input  logic [NSRC-1:0] pri_wdata,
  output logic [NSRC-1:0] src_en,
  output logic            pf_en,
  output logic            glb_en,
  output logic [NSRC-1:0] pri_q
);
  logic [NSRC+1:0] ien_q, ien_d;
  logic [NSRC-1:0] pri_d;

  always_comb begin
    ien_d = ien_q;
    pri_d = pri_q;
    if (ien_we) ien_d = ien_wdata;
    if (pri_we) pri_d = pri_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      pri_q <= '0;
    end else begin
      ien_q <= ien_d;
      pri_q <= pri_d;
    end
  end

  assign src_en = ien_q[NSRC-1:0];
  assign pf_en  = ien_q[NSRC];
  assign glb_en = ien_q[NSRC+1];
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_nest_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_en,
  input  lvl_e       set_lvl,
  input  logic       reti,
  output logic [2:0] ins_q,
  output lvl_e       cur_lvl
);
  logic [2:0] ins_d;

  always_comb begin
    ins_d = ins_q;
    if (reti) begin
      if (ins_q[2])      ins_d[2] = 1'b0;
      else if (ins_q[1]) ins_d[1] = 1'b0;
      else if (ins_q[0]) ins_d[0] = 1'b0;
    end
    if (set_en) begin
      case (set_lvl)
        LVL_LOW:  ins_d[0] = 1'b1;
        LVL_HIGH: ins_d[1] = 1'b1;
        LVL_PF:   ins_d[2] = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ins_q <= '0;
    else        ins_q <= ins_d;
  end

  always_comb begin
    if (ins_q[2])      cur_lvl = LVL_PF;
    else if (ins_q[1]) cur_lvl = LVL_HIGH;
    else if (ins_q[0]) cur_lvl = LVL_LOW;
    else               cur_lvl = LVL_NONE;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_nest_pkg::*;
#(
  parameter int unsigned NSRC   = 5,
  parameter int unsigned SLOT_W = 3
) (
  input  logic [NSRC-1:0]   req,
  input  logic [NSRC-1:0]   pri,
  input  logic              pf,
  input  lvl_e              cur_lvl,
  output logic              pick_vld,
  output logic [SLOT_W-1:0] pick_slot,
  output lvl_e              pick_lvl
);
  localparam int unsigned PF_SLOT = NSRC + 1;

  logic [NSRC-1:0]   hi_req, lo_req;
  logic [SLOT_W-1:0] hi_slot, lo_slot;

  assign hi_req = req & pri;
  assign lo_req = req & ~pri;

  always_comb begin
    hi_slot = '0;
    lo_slot = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hi_req[i]) hi_slot = SLOT_W'(i);
      if (lo_req[i]) lo_slot = SLOT_W'(i);
    end
  end

  always_comb begin
    pick_vld  = 1'b0;
    pick_slot = '0;
    pick_lvl  = LVL_NONE;
    if (pf && cur_lvl != LVL_PF) begin
      pick_vld  = 1'b1;
      pick_slot = SLOT_W'(PF_SLOT);
      pick_lvl  = LVL_PF;
    end else if ((|hi_req) && cur_lvl < LVL_HIGH) begin
      pick_vld  = 1'b1;
      pick_slot = hi_slot;
      pick_lvl  = LVL_HIGH;
    end else if ((|lo_req) && cur_lvl == LVL_NONE) begin
      pick_vld  = 1'b1;
      pick_slot = lo_slot;
      pick_lvl  = LVL_LOW;
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned NSRC     = 5,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req,
  input  logic             pf_req,
  input  logic             ien_we,
  input  logic [NSRC+1:0]  ien_wdata,
  input  logic             pri_we,
  input  logic [NSRC-1:0]  pri_wdata,
  input  logic             fetch_rdy,
  input  logic             reti,
  output logic             irq,
  output logic [VEC_W-1:0] vec_addr,
  output logic [NSRC-1:0]  src_ack,
  output logic             pf_ack
);
  localparam int unsigned PF_SLOT = NSRC + 1;
  localparam int unsigned SLOT_W  = $clog2(NSRC + 2);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [NSRC-1:0]   src_en, pri_q;
  logic              pf_en, glb_en;
  logic [NSRC-1:0]   req_q, req_d;
  logic              pf_q, pf_d;
  logic              pick_vld;
  logic [SLOT_W-1:0] pick_slot;
  lvl_e              pick_lvl, cur_lvl;
  logic              sel_vld_q, sel_vld_d;
  logic [SLOT_W-1:0] sel_slot_q, sel_slot_d;
  lvl_e              sel_lvl_q, sel_lvl_d;
  logic              accept;
  logic [2:0]        ins_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  irq_cfg_regs #(.NSRC(NSRC)) u_cfg (
    .clk(clk), .rst_n(rst_n_s),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .pri_we(pri_we), .pri_wdata(pri_wdata),
    .src_en(src_en), .pf_en(pf_en), .glb_en(glb_en), .pri_q(pri_q)
  );

  assign accept = sel_vld_q & fetch_rdy;

  // Request sampling stage; an acknowledged source is dropped at once.
  always_comb begin
    req_d = src_req & src_en & {NSRC{glb_en}} & ~src_ack;
    pf_d  = pf_req & pf_en & ~pf_ack;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      req_q <= '0;
      pf_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      pf_q  <= pf_d;
    end
  end

  irq_pick #(.NSRC(NSRC), .SLOT_W(SLOT_W)) u_pick (
    .req(req_q), .pri(pri_q), .pf(pf_q), .cur_lvl(cur_lvl),
    .pick_vld(pick_vld), .pick_slot(pick_slot), .pick_lvl(pick_lvl)
  );

  // Arbitration result stage; cleared for one cycle after a hand-over.
  always_comb begin
    sel_vld_d  = pick_vld;
    sel_slot_d = pick_slot;
    sel_lvl_d  = pick_lvl;
    if (accept) begin
      sel_vld_d  = 1'b0;
      sel_slot_d = '0;
      sel_lvl_d  = LVL_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sel_vld_q  <= 1'b0;
      sel_slot_q <= '0;
      sel_lvl_q  <= LVL_NONE;
    end else begin
      sel_vld_q  <= sel_vld_d;
      sel_slot_q <= sel_slot_d;
      sel_lvl_q  <= sel_lvl_d;
    end
  end

  irq_inservice u_ins (
    .clk(clk), .rst_n(rst_n_s),
    .set_en(accept), .set_lvl(sel_lvl_q), .reti(reti),
    .ins_q(ins_flags), .cur_lvl(cur_lvl)
  );

  assign irq      = sel_vld_q;
  assign vec_addr = sel_vld_q ? VEC_W'(VEC_BASE + VEC_STEP * int'(sel_slot_q)) : '0;
  assign pf_ack   = accept & (sel_slot_q == SLOT_W'(PF_SLOT));

  for (genvar g = 0; g < NSRC; g++) begin : g_ack
    assign src_ack[g] = accept & (sel_slot_q == SLOT_W'(g));
  end
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int unsigned NSRC  = 5,
  parameter int unsigned VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_rdy,
  input logic             reti,
  input logic             irq,
  input logic [VEC_W-1:0] vec_addr,
  input logic [NSRC-1:0]  src_ack,
  input logic             pf_ack,
  input logic [2:0]       ins_flags
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pf_ack, src_ack})); // R11
  AST_ACK_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|{pf_ack, src_ack}) |-> (fetch_rdy && irq)); // R11
  AST_ACK_RETIRES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|{pf_ack, src_ack}) |=> !irq); // R11
  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (vec_addr == '0)); // R6
  AST_PF_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_ack |=> ins_flags[2]); // R9
  AST_NO_SRC_ACK_UNDER_PF: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_ack) |-> !ins_flags[2]); // R9
  AST_FLAGS_HOLD_NO_RETI: assert property (@(posedge clk) disable iff (!rst_n)
    !reti |=> ((ins_flags & $past(ins_flags)) == $past(ins_flags))); // R10
endmodule

bind irq_nest_ctrl irq_nest_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .fetch_rdy(fetch_rdy), .reti(reti),
  .irq(irq), .vec_addr(vec_addr), .src_ack(src_ack), .pf_ack(pf_ack),
  .ins_flags(ins_flags)
);

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;
  localparam int NSRC = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src_req;
  logic            pf_req;
  logic            ien_we;
  logic [NSRC+1:0] ien_wdata;
  logic            pri_we;
  logic [NSRC-1:0] pri_wdata;
  logic            fetch_rdy;
  logic            reti;
  logic            irq;
  logic [15:0]     vec_addr;
  logic [NSRC-1:0] src_ack;
  logic            pf_ack;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_nest_ctrl u_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .pf_req(pf_req),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .pri_we(pri_we), .pri_wdata(pri_wdata),
    .fetch_rdy(fetch_rdy), .reti(reti), .irq(irq), .vec_addr(vec_addr),
    .src_ack(src_ack), .pf_ack(pf_ack)
  );

  // Row: enable[6:0], priority[4:0], src_req[4:0], pf_req, expected vector
  localparam int NROW = 11;
  localparam logic [33:0] TBL [NROW] = '{
    {7'h01, 5'h00, 5'h01, 1'b0, 16'h0000}, // R2 global enable off
    {7'h41, 5'h00, 5'h01, 1'b0, 16'h0003}, // R2 both enables on
    {7'h40, 5'h00, 5'h01, 1'b0, 16'h0000}, // R2 own enable off
    {7'h5F, 5'h00, 5'h1F, 1'b0, 16'h0003}, // R4 all pending
    {7'h5F, 5'h00, 5'h1C, 1'b0, 16'h0013}, // R4 external 1 first
    {7'h5F, 5'h00, 5'h18, 1'b0, 16'h001B}, // R4 timer 1 before serial
    {7'h5F, 5'h10, 5'h1F, 1'b0, 16'h0023}, // R5 serial on high level
    {7'h5F, 5'h0A, 5'h0B, 1'b0, 16'h000B}, // R5 R4 order among highs
    {7'h20, 5'h00, 5'h00, 1'b1, 16'h0033}, // R3 power-fail without global
    {7'h40, 5'h00, 5'h00, 1'b1, 16'h0000}, // R3 power-fail enable off
    {7'h7F, 5'h1F, 5'h1F, 1'b1, 16'h0033}  // R3 R6 power-fail beats all
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_req = '0; pf_req = 1'b0; ien_we = 1'b0; ien_wdata = '0;
    pri_we = 1'b0; pri_wdata = '0; fetch_rdy = 1'b0; reti = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic cfg(input logic [6:0] ien, input logic [4:0] pri);
    ien_we = 1'b1; ien_wdata = ien; pri_we = 1'b1; pri_wdata = pri;
    step(1);
    ien_we = 1'b0; pri_we = 1'b0;
  endtask

  // Raise fetch_rdy for one cycle and compare the acknowledges seen in it.
  task automatic fetch(input string tag, input logic [4:0] exp_src, input logic exp_pf);
    fetch_rdy = 1'b1;
    #1;
    chk(tag, {26'd0, pf_ack, src_ack}, {26'd0, exp_pf, exp_src});
    step(1);
    fetch_rdy = 1'b0;
  endtask

  task automatic ret_pulse();
    reti = 1'b1;
    step(1);
    reti = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    // R1: reset state with every request line high
    do_reset();
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 vec after reset", {16'd0, vec_addr}, 32'd0);
    src_req = 5'h1F; pf_req = 1'b1;
    step(4);
    chk("R1 no irq while disabled", {31'd0, irq}, 32'd0);
    chk("R1 no ack while disabled", {26'd0, pf_ack, src_ack}, 32'd0);

    // Table walk: R2 R3 R4 R5 R6 R11
    for (int r = 0; r < NROW; r++) begin
      logic [15:0] ev;
      logic [4:0]  es;
      logic        ep;
      ev = TBL[r][15:0];
      es = '0;
      ep = 1'b0;
      if (ev == 16'h0033) ep = 1'b1;
      else if (ev != 16'h0000) es = 5'(1 << ((ev - 16'h3) / 8));
      do_reset();
      cfg(TBL[r][33:27], TBL[r][26:22]);
      src_req = TBL[r][21:17];
      pf_req  = TBL[r][16];
      step(4);
      chk($sformatf("R6 table row %0d vector", r), {16'd0, vec_addr}, {16'd0, ev});
      chk($sformatf("R6 table row %0d irq", r), {31'd0, irq}, {31'd0, (ev != 16'h0)});
      fetch($sformatf("R11 table row %0d ack", r), es, ep);
      src_req = '0; pf_req = 1'b0;
    end

    // R12: two-edge latency
    do_reset();
    cfg(7'h44, 5'h00);
    src_req = 5'h04;
    step(1);
    chk("R12 irq low after one edge", {31'd0, irq}, 32'd0);
    step(1);
    chk("R12 irq high after two edges", {31'd0, irq}, 32'd1);
    chk("R12 vector external 1", {16'd0, vec_addr}, 32'h13);

    // R11: no hand-over without fetch_rdy
    step(5);
    chk("R11 no ack without fetch", {26'd0, pf_ack, src_ack}, 32'd0);
    chk("R11 irq held while waiting", {31'd0, irq}, 32'd1);
    fetch("R11 ack external 1", 5'h04, 1'b0);
    src_req = '0;
    chk("R11 irq falls after ack", {31'd0, irq}, 32'd0);

    // R7 R8 R10: nesting of high over low
    do_reset();
    cfg(7'h5F, 5'h08);
    src_req = 5'h02;
    step(4);
    chk("R7 low timer 0 vector", {16'd0, vec_addr}, 32'h0B);
    fetch("R11 ack timer 0", 5'h02, 1'b0);
    src_req = 5'h01;
    step(4);
    chk("R8 external 0 blocked by same level", {31'd0, irq}, 32'd0);
    src_req = 5'h09;
    step(4);
    chk("R7 high timer 1 preempts low", {16'd0, vec_addr}, 32'h1B);
    fetch("R11 ack timer 1", 5'h08, 1'b0);
    src_req = 5'h01;
    step(4);
    chk("R8 external 0 blocked under high", {31'd0, irq}, 32'd0);
    ret_pulse();
    step(3);
    chk("R10 low still in service after one reti", {31'd0, irq}, 32'd0);
    ret_pulse();
    step(3);
    chk("R10 external 0 taken after second reti", {16'd0, vec_addr}, 32'h03);
    src_req = '0;

    // R9: power-fail over high, then unwind
    do_reset();
    cfg(7'h7F, 5'h08);
    src_req = 5'h08;
    step(4);
    fetch("R11 ack timer 1 before power-fail", 5'h08, 1'b0);
    src_req = '0;
    pf_req = 1'b1;
    step(4);
    chk("R9 power-fail preempts high", {16'd0, vec_addr}, 32'h33);
    fetch("R9 power-fail ack", 5'h00, 1'b1);
    pf_req = 1'b0;
    src_req = 5'h08;
    step(4);
    chk("R9 high blocked under power-fail", {31'd0, irq}, 32'd0);
    ret_pulse();
    step(3);
    chk("R10 high still in service", {31'd0, irq}, 32'd0);
    ret_pulse();
    step(3);
    chk("R10 timer 1 taken after unwind", {16'd0, vec_addr}, 32'h1B);
    src_req = '0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule